// File: doc/BRIEF.md
# Next-PC and Branch Target Unit

This combinational block decides where a 32-bit RISC core with fixed four-byte instructions fetches next. From the current fetch address, the 16-bit immediate and 26-bit target fields of the instruction, a register operand, and an equality result from the compare unit, it selects one of several next-address sources. The sources are the sequential address, a PC-relative branch target, a region-relative (pseudo-direct) jump target, and a register target. It also produces the return address for calls.

The decoder drives a 3-bit flow code. The register file supplies the operand, and the ALU supplies the equality flag. The same block supplies the ALU's 32-bit immediate operand. The decoder chooses sign or zero extension for that operand, per instruction.

Top module: `npc_unit`

## Requirements
- R1: With flow code 0 (sequential), `next_pc_o` equals `pc_i + 4` (modulo 2^32) and `link_we_o` is 0.
- R2: With flow code 1 (branch-if-equal), `next_pc_o` equals `pc_i + 4 + (sign-extended imm_i << 2)` when `eq_i` is 1, and `pc_i + 4` when `eq_i` is 0.
- R3: With flow code 2 (branch-if-not-equal), the branch target is taken when `eq_i` is 0, and `pc_i + 4` is selected when `eq_i` is 1.
- R4: Branch offsets are signed word counts. `imm_i` = 0x8000 reaches 32768 instructions back from `pc_i + 4`, and `imm_i` = 0x7FFF reaches 32767 instructions forward. The address arithmetic wraps modulo 2^32.
- R5: With flow code 3 (jump), `next_pc_o` equals `{(pc_i+4)[31:28], tgt_i, 2'b00}`. The upper four bits come from the incremented PC, not from `pc_i`.
- R6: With flow code 4 (jump-and-link), `next_pc_o` is the same as for R5 and `link_we_o` is 1. `link_o` always equals `pc_i + 4`, and `link_we_o` is 0 for every other flow code.
- R7: With flow code 5 (jump-register), `next_pc_o` equals `reg_i` unchanged.
- R8: `misalign_o` is 1 only when the flow code is 5 and `reg_i[1:0]` is non-zero.
- R9: `imm_o` is `imm_i` sign-extended to 32 bits when `imm_signed_i` is 1, and zero-extended when it is 0, for every flow code.
- R10: Flow codes 6 and 7 act as sequential: `next_pc_o` equals `pc_i + 4`, and `link_we_o` and `misalign_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| flow_i | input | 3 | Flow code from decode (0 seq, 1 beq, 2 bne, 3 jump, 4 jump-and-link, 5 jump-register) |
| eq_i | input | 1 | Compare result, 1 when the operands are equal |
| imm_i | input | 16 | Instruction immediate field |
| tgt_i | input | 26 | Instruction jump target field |
| reg_i | input | 32 | Register operand for jump-register |
| imm_signed_i | input | 1 | 1 selects sign extension of the ALU immediate |
| next_pc_o | output | 32 | Next fetch address |
| link_o | output | 32 | Return address (PC + 4) |
| link_we_o | output | 1 | Write enable for the return-address register |
| misalign_o | output | 1 | Jump-register target not word aligned |
| imm_o | output | 32 | Extended immediate for the ALU |

## Verification
The block holds no state, so any fault appears on the ports in the same evaluation as the stimulus that exposes it. A wrong incrementer constant or shift shows as every branch target off by a fixed stride. A region taken from the unincremented PC shows only when the jump sits in the last word of a 256 MB region. A sign error in the offset extension shows only for immediates with bit 15 set. Both of those cases are therefore driven directly, in addition to random vectors.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    FLOW_SEQ = 3'd0,
    FLOW_BEQ = 3'd1,
    FLOW_BNE = 3'd2,
    FLOW_J   = 3'd3,
    FLOW_JAL = 3'd4,
    FLOW_JR  = 3'd5
  } flow_e;
endpackage

// File: rtl/npc_imm_ext.sv
module npc_imm_ext #(
  parameter int IMM_W = 16,
  parameter int XLEN  = 32
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic             signed_i,
  output logic [XLEN-1:0]  ext_o
);
  localparam int PAD_W = XLEN - IMM_W;

  generate
    if (PAD_W > 0) begin : g_pad
      logic fill;
      assign fill  = signed_i & imm_i[IMM_W-1];
      assign ext_o = {{PAD_W{fill}}, imm_i};
    end else begin : g_trunc
      logic unused_sign;
      assign unused_sign = signed_i;
      assign ext_o = imm_i[XLEN-1:0];
    end
  endgenerate
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
  parameter int XLEN        = 32,
  parameter int TGT_W       = 26,
  parameter int INSTR_BYTES = 4
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  off_i,   // sign-extended word offset
  input  logic [TGT_W-1:0] tgt_i,
  output logic [XLEN-1:0]  pc_inc_o,
  output logic [XLEN-1:0]  br_tgt_o,
  output logic [XLEN-1:0]  jmp_tgt_o
);
  localparam int SH   = $clog2(INSTR_BYTES);
  localparam int HI_W = XLEN - TGT_W - SH;

  assign pc_inc_o  = pc_i + XLEN'(INSTR_BYTES);
  assign br_tgt_o  = pc_inc_o + (off_i << SH);
  // region bits from the incremented PC so a jump in a region's last slot stays consistent
  assign jmp_tgt_o = {pc_inc_o[XLEN-1 -: HI_W], tgt_i, {SH{1'b0}}};
endmodule

// File: rtl/npc_sel.sv
module npc_sel
  import npc_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic [2:0]      flow_i,
  input  logic            eq_i,
  input  logic [XLEN-1:0] pc_inc_i,
  input  logic [XLEN-1:0] br_tgt_i,
  input  logic [XLEN-1:0] jmp_tgt_i,
  input  logic [XLEN-1:0] reg_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            link_we_o,
  output logic            misalign_o
);
  localparam int SH = $clog2(INSTR_BYTES);

  flow_e flow;
  assign flow = flow_e'(flow_i);

  always_comb begin
    next_pc_o  = pc_inc_i;
    link_we_o  = 1'b0;
    misalign_o = 1'b0;
    case (flow)
      FLOW_BEQ: if (eq_i)  next_pc_o = br_tgt_i;
      FLOW_BNE: if (!eq_i) next_pc_o = br_tgt_i;
      FLOW_J:   next_pc_o = jmp_tgt_i;
      FLOW_JAL: begin
        next_pc_o = jmp_tgt_i;
        link_we_o = 1'b1;
      end
      FLOW_JR: begin
        next_pc_o  = reg_i;
        misalign_o = |reg_i[SH-1:0];
      end
      default: next_pc_o = pc_inc_i;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int XLEN        = 32,
  parameter int IMM_W       = 16,
  parameter int TGT_W       = 26,
  parameter int INSTR_BYTES = 4
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [2:0]       flow_i,
  input  logic             eq_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [TGT_W-1:0] tgt_i,
  input  logic [XLEN-1:0]  reg_i,
  input  logic             imm_signed_i,
  output logic [XLEN-1:0]  next_pc_o,
  output logic [XLEN-1:0]  link_o,
  output logic             link_we_o,
  output logic             misalign_o,
  output logic [XLEN-1:0]  imm_o
);
  logic [XLEN-1:0] off_sx, pc_inc, br_tgt, jmp_tgt;

  // branch offsets are always signed
  npc_imm_ext #(.IMM_W(IMM_W), .XLEN(XLEN)) i_off_ext (
    .imm_i(imm_i), .signed_i(1'b1), .ext_o(off_sx)
  );

  // ALU operand, extension picked by decode
  npc_imm_ext #(.IMM_W(IMM_W), .XLEN(XLEN)) i_alu_ext (
    .imm_i(imm_i), .signed_i(imm_signed_i), .ext_o(imm_o)
  );

  npc_target_gen #(.XLEN(XLEN), .TGT_W(TGT_W), .INSTR_BYTES(INSTR_BYTES)) i_tgt (
    .pc_i(pc_i), .off_i(off_sx), .tgt_i(tgt_i),
    .pc_inc_o(pc_inc), .br_tgt_o(br_tgt), .jmp_tgt_o(jmp_tgt)
  );

  npc_sel #(.XLEN(XLEN), .INSTR_BYTES(INSTR_BYTES)) i_sel (
    .flow_i(flow_i), .eq_i(eq_i), .pc_inc_i(pc_inc), .br_tgt_i(br_tgt),
    .jmp_tgt_i(jmp_tgt), .reg_i(reg_i),
    .next_pc_o(next_pc_o), .link_we_o(link_we_o), .misalign_o(misalign_o)
  );

  assign link_o = pc_inc;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
  input logic [31:0] pc_i,
  input logic [2:0]  flow_i,
  input logic        eq_i,
  input logic [15:0] imm_i,
  input logic [31:0] reg_i,
  input logic        imm_signed_i,
  input logic [31:0] next_pc_o,
  input logic [31:0] link_o,
  input logic        link_we_o,
  input logic        misalign_o,
  input logic [31:0] imm_o
);
  logic known;
  assign known = !$isunknown({pc_i, flow_i, eq_i, imm_i, reg_i, imm_signed_i});

  always_comb begin
    if (known) begin
      p_seq_step_r1: assert (flow_i != 3'd0 || next_pc_o == link_o);
      p_beq_fall_r2: assert (!(flow_i == 3'd1 && !eq_i) || next_pc_o == link_o);
      p_bne_fall_r3: assert (!(flow_i == 3'd2 && eq_i) || next_pc_o == link_o);
      p_jump_region_r5: assert (!(flow_i == 3'd3 || flow_i == 3'd4) ||
                                (next_pc_o[31:28] == link_o[31:28] && next_pc_o[1:0] == 2'b00));
      p_link_only_jal_r6: assert (link_we_o == (flow_i == 3'd4));
      p_link_step_r6: assert (link_o - pc_i == 32'd4);
      p_jr_follow_r7: assert (flow_i != 3'd5 || next_pc_o == reg_i);
      p_misalign_src_r8: assert (!misalign_o || (flow_i == 3'd5 && reg_i[1:0] != 2'b00));
      p_imm_low_r9: assert (imm_o[15:0] == imm_i);
      p_imm_zero_r9: assert (imm_signed_i || imm_o[31:16] == 16'h0000);
      p_spare_seq_r10: assert (flow_i < 3'd6 || (next_pc_o == link_o && !misalign_o));
    end
  end
endmodule

bind npc_unit npc_unit_chk i_npc_unit_chk (
  .pc_i(pc_i), .flow_i(flow_i), .eq_i(eq_i), .imm_i(imm_i), .reg_i(reg_i),
  .imm_signed_i(imm_signed_i), .next_pc_o(next_pc_o), .link_o(link_o),
  .link_we_o(link_we_o), .misalign_o(misalign_o), .imm_o(imm_o)
);

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;
  logic        clk = 1'b0;
  logic [31:0] pc, rg;
  logic [2:0]  flow;
  logic        eq, sgn;
  logic [15:0] imm;
  logic [25:0] tgt;
  logic [31:0] next_pc, link, immx;
  logic        link_we, misalign;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  npc_unit i_npc_unit (
    .pc_i(pc), .flow_i(flow), .eq_i(eq), .imm_i(imm), .tgt_i(tgt), .reg_i(rg),
    .imm_signed_i(sgn), .next_pc_o(next_pc), .link_o(link), .link_we_o(link_we),
    .misalign_o(misalign), .imm_o(immx)
  );

  function automatic logic [31:0] exp_next(logic [2:0] f, logic e, logic [31:0] p,
                                           logic [15:0] i, logic [25:0] t, logic [31:0] r);
    logic [31:0] inc, br;
    inc = p + 32'd4;
    br  = inc + {{14{i[15]}}, i, 2'b00};
    case (f)
      3'd1: return e ? br : inc;
      3'd2: return e ? inc : br;
      3'd3, 3'd4: return {inc[31:28], t, 2'b00};
      3'd5: return r;
      default: return inc;
    endcase
  endfunction

  function automatic logic [31:0] exp_imm(logic [15:0] i, logic s);
    return s ? {{16{i[15]}}, i} : {16'h0000, i};
  endfunction

  function automatic string req_of(logic [2:0] f);
    case (f)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] p, logic [2:0] f, logic e, logic [15:0] i,
                       logic [25:0] t, logic [31:0] r, logic s, string req);
    @(posedge clk);
    pc = p; flow = f; eq = e; imm = i; tgt = t; rg = r; sgn = s;
    #5;
    chk(req, next_pc, exp_next(f, e, p, i, t, r));
    chk("R6 link", link, p + 32'd4);
    chk("R6 link_we", {31'd0, link_we}, {31'd0, f == 3'd4});
    chk("R8", {31'd0, misalign}, {31'd0, f == 3'd5 && r[1:0] != 2'b00});
    chk("R9", immx, exp_imm(i, s));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    pc = '0; flow = '0; eq = 1'b0; imm = '0; tgt = '0; rg = '0; sgn = 1'b0;
    #5;
    chk("R1 idle", next_pc, 32'h0000_0004);
    chk("R9 idle", immx, 32'h0);
    // R2/R3 directed taken and not taken
    apply(32'h0040_0010, 3'd1, 1'b1, 16'h0003, '0, '0, 1'b1, "R2 taken");
    apply(32'h0040_0010, 3'd1, 1'b0, 16'h0003, '0, '0, 1'b1, "R2 fall");
    apply(32'h0040_0010, 3'd2, 1'b0, 16'hFFFE, '0, '0, 1'b0, "R3 taken");
    apply(32'h0040_0010, 3'd2, 1'b1, 16'hFFFE, '0, '0, 1'b0, "R3 fall");
    // R4 reach limits and wrap
    apply(32'h0010_0000, 3'd1, 1'b1, 16'h8000, '0, '0, 1'b1, "R4 back");
    chk("R4 back abs", next_pc, 32'h0010_0004 - 32'h0002_0000);
    apply(32'h0010_0000, 3'd1, 1'b1, 16'h7FFF, '0, '0, 1'b1, "R4 fwd");
    chk("R4 fwd abs", next_pc, 32'h0010_0004 + 32'h0001_FFFC);
    apply(32'h0000_0000, 3'd2, 1'b0, 16'hFFFE, '0, '0, 1'b1, "R4 wrap");
    chk("R4 wrap abs", next_pc, 32'hFFFF_FFFC);
    // R5 region boundary: upper bits from pc+4
    apply(32'h0FFF_FFFC, 3'd3, 1'b0, '0, 26'h000_0010, '0, 1'b0, "R5 region");
    chk("R5 region abs", next_pc, 32'h1000_0040);
    apply(32'hFFFF_FFFC, 3'd4, 1'b0, '0, 26'h3FF_FFFF, '0, 1'b0, "R6 wrap");
    chk("R6 wrap abs", next_pc, 32'h0FFF_FFFC);
    // R7/R8 aligned and each misaligned low pattern
    apply(32'h0000_1000, 3'd5, 1'b1, '0, '0, 32'h8000_0000, 1'b0, "R7 aligned");
    for (int k = 1; k < 4; k++)
      apply(32'h0000_1000, 3'd5, 1'b0, '0, '0, 32'h1234_5670 | k, 1'b0, "R7 misaligned");
    // R8 misaligned operand ignored by non-register flows
    apply(32'h0000_1000, 3'd0, 1'b0, '0, '0, 32'h0000_0003, 1'b1, "R1 odd reg");
    // R10 spare codes
    apply(32'h0000_2000, 3'd6, 1'b1, 16'h0100, 26'h1, 32'h7, 1'b1, "R10 code6");
    apply(32'h0000_2000, 3'd7, 1'b0, 16'h0100, 26'h1, 32'h7, 1'b0, "R10 code7");
    // R9 both extensions on a negative immediate
    apply(32'h0, 3'd0, 1'b0, 16'h8001, '0, '0, 1'b1, "R9 sign");
    apply(32'h0, 3'd0, 1'b0, 16'h8001, '0, '0, 1'b0, "R9 zero");
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [2:0] f;
      f = 3'($urandom_range(0, 7));
      apply($urandom, f, 1'($urandom), 16'($urandom), 26'($urandom), $urandom,
            1'($urandom), req_of(f));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule